// File: doc/BRIEF.md
# Watermarked Audio Channel FIFO

One channel of a multi-channel audio sample buffer. The block holds up to 512 words of 32 bits. In capture use the audio hardware writes samples and software reads them out. In playback use software writes samples and the audio hardware consumes them. The storage and the pointers behave the same in both directions. The direction input only selects which half of the status byte carries the flags.

Two 9-bit thresholds share one configuration word. They set the level that raises the almost-full flag and the level that raises the almost-empty flag. The raw read and write positions are exposed in one status word, so software can work out used or free space without a separate level register. A synchronous clear input empties the channel at once.

Top module: `audio_chan_fifo`

## Requirements
- R1: After reset both pointers are zero, the empty flag is set, the full flag is clear, `ovf` is low and `rd_data` is zero.
- R2: Words leave in the order they were accepted. An accepted read on edge k presents the word on `rd_data` from edge k onward, and `rd_data` holds it until the next accepted read.
- R3: The full flag is set when 512 words are held. A write while full is dropped, even when a read happens in the same cycle, and `ovf` is high for exactly the one cycle after that edge.
- R4: A read while empty is ignored: `rd_data` keeps its last value and the read pointer does not move.
- R5: Almost-full is set whenever the held word count is greater than or equal to `thr_word[8:0]`.
- R6: Almost-empty is set whenever the held word count is less than or equal to `thr_word[24:16]`.
- R7: A status nibble is {almost-empty, almost-full, empty, full}, with full in the lowest bit. With `play_mode`=0 it sits in `flags[3:0]` and `flags[7:4]` is zero. With `play_mode`=1 it sits in `flags[7:4]` and `flags[3:0]` is zero.
- R8: `ptr_word` carries the read position in bits 25:16 and the write position in bits 9:0, and all other bits are zero. Positions run 0 to 511 and wrap to 0. When the channel is not full, the used bytes are 4*(w-r) for w>=r and 4*(512-r+w) otherwise. The free bytes are 4*(512-w+r) for w>=r and 4*(r-w) otherwise.
- R9: `clr` sampled high empties the channel at that edge. Both positions become zero, and a write or read in the same cycle has no effect and raises no `ovf`.
- R10: A read and a write in the same cycle on a channel that is neither empty nor full leave the word count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous channel clear |
| play_mode | input | 1 | 0 capture, 1 playback (flag placement) |
| thr_word | input | 32 | Thresholds: almost-empty 24:16, almost-full 8:0 |
| wr_en | input | 1 | Write request |
| wr_data | input | 32 | Write word |
| rd_en | input | 1 | Read request |
| rd_data | output | 32 | Last word read |
| flags | output | 8 | Status byte, see R7 |
| ovf | output | 1 | One-cycle overflow pulse |
| ptr_word | output | 32 | Read and write positions, see R8 |

## Verification
Flags and `ptr_word` follow the word count combinationally, so they are due just after the edge that accepts a request. A read's word and the `ovf` pulse are registered at that same edge, so all of them are checked one time step after the rising edge that took the stimulus. The bench drives every request on the falling edge and compares right after the next rising edge. A queue of expected words is filled when a write is predicted to be accepted and emptied when a read is.

// File: rtl/audio_chan_fifo.sv
module audio_chan_fifo #(
  parameter int DEPTH = 512,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          play_mode,
  input  logic [31:0]   thr_word,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic [7:0]    flags,
  output logic          ovf,
  output logic [31:0]   ptr_word
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic          full, empty, wr_ok, rd_ok;
  logic [CW-1:0] af_lvl, ae_lvl;
  logic [3:0]    nib;
  logic          unused_thr_bits;

  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);
  assign wr_ok = wr_en && !full && !clr;
  assign rd_ok = rd_en && !empty && !clr;

  assign af_lvl = CW'(thr_word[8:0]);
  assign ae_lvl = CW'(thr_word[24:16]);
  assign unused_thr_bits = ^{thr_word[31:25], thr_word[15:9]};

  assign nib   = {cnt <= ae_lvl, cnt >= af_lvl, empty, full};
  assign flags = play_mode ? {nib, 4'b0} : {4'b0, nib};

  assign ptr_word = ({{(32-AW){1'b0}}, rptr} << 16) | {{(32-AW){1'b0}}, wptr};

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr    <= '0;
      rptr    <= '0;
      cnt     <= '0;
      rd_data <= '0;
      ovf     <= 1'b0;
    end else if (clr) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
      ovf  <= 1'b0;
    end else begin
      ovf <= wr_en && full;
      if (wr_ok) wptr <= wptr + AW'(1);
      if (rd_ok) begin
        rptr    <= rptr + AW'(1);
        rd_data <= mem[rptr];
      end
      case ({wr_ok, rd_ok})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH)); // R3
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en && !clr) |=> (ovf && $stable(wptr))); // R3
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rd_en && !wr_en && !clr) |=> ($stable(rptr) && $stable(rd_data))); // R4
  AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (empty && wptr == '0 && rptr == '0 && !ovf)); // R9
  AST_RW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_en && !clr && !empty && !full) |=> $stable(cnt)); // R10
  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(flags[0] && flags[1]) && !(flags[4] && flags[5])); // R7
endmodule

// File: tb/audio_chan_fifo_tb.sv
`timescale 1ns/1ps
module audio_chan_fifo_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0, play_mode = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] thr_word = 32'h0;
  logic [31:0] wr_data = 32'h0;
  logic [31:0] rd_data, ptr_word;
  logic [7:0]  flags;
  logic        ovf;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int cnt = 0, wp = 0, rp = 0;
  logic [31:0] last_rd = 32'h0;
  bit exp_ovf = 0;
  logic [31:0] sb[$];

  always #2.5 clk = ~clk;

  audio_chan_fifo u_dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .play_mode(play_mode),
    .thr_word(thr_word), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .flags(flags), .ovf(ovf), .ptr_word(ptr_word));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_state();
    logic [3:0] nib;
    int w, r, ae, af;
    ae = int'(thr_word[24:16]);
    af = int'(thr_word[8:0]);
    nib = {cnt <= ae, cnt >= af, cnt == 0, cnt == 512};
    check("R7 flags (R3 R5 R6)", {24'h0, flags}, play_mode ? {24'h0, nib, 4'h0} : {28'h0, nib});
    check("R8 ptr_word", ptr_word, (32'(rp) << 16) | 32'(wp));
    check("R3 ovf", {31'h0, ovf}, {31'h0, exp_ovf});
    check("R2 rd_data", rd_data, last_rd);
    if (cnt != 512) begin
      w = int'(ptr_word[9:0]);
      r = int'(ptr_word[25:16]);
      check("R8 used bytes", 32'((w >= r) ? 4*(w-r) : 4*(512-r+w)), 32'(4*cnt));
      check("R8 free bytes", 32'((w >= r) ? 4*(512-w+r) : 4*(r-w)), 32'(4*(512-cnt)));
    end
  endtask

  task automatic cyc(input bit wr, input logic [31:0] wd, input bit rd, input bit cl);
    bit rd_ok, wr_ok;
    @(negedge clk);
    wr_en = wr; wr_data = wd; rd_en = rd; clr = cl;
    @(posedge clk);
    #1;
    if (cl) begin
      cnt = 0; wp = 0; rp = 0; exp_ovf = 0; sb.delete();
    end else begin
      rd_ok = rd && cnt > 0;
      wr_ok = wr && cnt < 512;
      exp_ovf = wr && cnt == 512;
      if (rd_ok) begin last_rd = sb.pop_front(); rp = (rp + 1) % 512; cnt--; end
      if (wr_ok) begin sb.push_back(wd); wp = (wp + 1) % 512; cnt++; end
    end
    check_state();
    wr_en = 0; rd_en = 0; clr = 0;
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
      $finish;
    end
  end

  initial begin
    int prev_rp;
    logic [31:0] held;
    thr_word = {7'h0, 9'd2, 7'h0, 9'd4};
    #12 rst_n = 1'b1;
    @(negedge clk);
    check_state(); // R1
    check("R1 empty flag", {24'h0, flags}, 32'h0000000A);
    check("R1 rd_data", rd_data, 32'h0);

    for (int i = 0; i < 6; i++) cyc(1, 32'hA500_0000 + i, 0, 0); // R5 R6 rising
    for (int i = 0; i < 3; i++) cyc(0, 0, 1, 0);                  // R2
    for (int i = 0; i < 4; i++) cyc(1, 32'hB000_0000 + i, 1, 0); // R10
    check("R10 count kept", 32'(ptr_word[9:0] - ptr_word[25:16]), 32'd3);
    play_mode = 1'b1;
    cyc(0, 0, 0, 0);                                             // R7 playback nibble
    while (cnt > 0) cyc(0, 0, 1, 0);
    held = rd_data;
    prev_rp = int'(ptr_word[25:16]);
    cyc(0, 0, 1, 0);                                             // R4
    check("R4 rd_data held", rd_data, held);
    check("R4 rptr unmoved", 32'(ptr_word[25:16]), 32'(prev_rp));
    play_mode = 1'b0;

    thr_word = {7'h0, 9'd10, 7'h0, 9'd500};
    for (int i = 0; i < 512; i++) cyc(1, 32'hC000_0000 + i, 0, 0);
    check("R3 full flag", {31'h0, flags[0]}, 32'h1);
    cyc(1, 32'hDEAD_BEEF, 0, 0);                                 // R3 dropped write
    check("R3 ovf pulse", {31'h0, ovf}, 32'h1);
    cyc(0, 0, 0, 0);
    check("R3 ovf one cycle", {31'h0, ovf}, 32'h0);
    cyc(1, 32'hDEAD_0001, 1, 0);                                 // R3 full with read
    while (cnt > 0) cyc(0, 0, 1, 0);                             // R2 order across wrap

    for (int i = 0; i < 5; i++) cyc(1, 32'hE000_0000 + i, 0, 0);
    cyc(1, 32'hE0FF_FFFF, 1, 1);                                 // R9
    check("R9 cleared ptr", ptr_word, 32'h0);
    check("R9 empty", {24'h0, flags}, 32'h0000000A);
    cyc(1, 32'hF000_0001, 0, 0);
    cyc(0, 0, 1, 0);
    check("R9 first word after clear", rd_data, 32'hF000_0001);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule